// File: doc/BRIEF.md
# Four-Channel PWM Generator with Latched Break Override

This block drives four pulse-width outputs from one shared up-counter. The counter is 12 bits wide. It starts at a reload value supplied on a port, counts to all-ones and then wraps back to the reload value. The span between the reload value and all-ones sets the period. Each channel holds a 12-bit duty value. When the channel is enabled, its output is high while the counter is below the duty value and low for the rest of the period. Every channel also produces a compare-hit pulse in the cycle where the counter equals its duty value, whether or not the channel's output is enabled. This lets a disabled channel serve as a plain output-compare timer.

Software writes duty values through a byte-wide register port. Each write lands in a shadow copy. The shadow moves into the live compare value only when the counter wraps, so a period is never cut short or stretched by a write in mid-period.

An external break pin is sampled through a two-stage synchronizer. It is armed by an enable bit. Once it fires, a latch forces all four outputs to a programmed 4-bit pattern. The latch stays set until software clears it.

Top module: `pwm_break_gen`

## Requirements
- R1: While `cnt_en` is 1 the counter rises by one per clock. When it sits at 0xFFF it loads `reload_val` on the next clock instead, and `ovf` is 1 during that 0xFFF cycle only. While `cnt_en` is 0 the counter holds and `ovf` is 0.
- R2: With channel output-enable 1 and no break, the output is 1 exactly when the counter is below the channel's live duty value. A duty value at or below the reload value therefore gives a constant 0.
- R3: With channel output-enable 0 and no break, the channel output is 0.
- R4: Duty writes update the shadow copy at once, and readback returns the shadow. The live compare value takes the shadow only on a clock where `ovf` is 1.
- R5: `cmp_hit[i]` is 1 exactly when the counter equals channel i's live duty value, for either output-enable setting.
- R6: While the break enable bit (bit 4 at address 9) is 0, the break pin never sets the break latch.
- R7: With break enabled, a high break pin sampled on a clock edge sets the latch two edges later. While the latch is set, every output bit equals the matching bit of the break pattern (bits 3:0 at address 9).
- R8: The latch stays set after the pin falls. Writing 1 to bit 6 at address 9 clears it, unless the synchronized pin is high and break is enabled on that same edge, in which case it stays set. Bit 5 at address 9 reads the latch state; bit 6 reads 0.
- R9: Register map. Address 2*i holds duty bits 7:0 of channel i. Address 2*i+1 holds duty bits 11:8 in its bits 3:0, and its bits 7:4 read 0. Address 8 holds the output-enable bits 3:0, one per channel. Address 9 holds the break control. Any other address reads 0. `rdata` is combinational from `addr`.
- R10: After reset, all duty values, output enables, the break enable, the pattern, the latch and the counter are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cnt_en | input | 1 | Counter enable |
| reload_val | input | 12 | Value loaded after the counter reaches 0xFFF |
| brk_in | input | 1 | Asynchronous break request, active high |
| pwm_out | output | 4 | Channel outputs |
| cmp_hit | output | 4 | Per-channel counter equals live duty |
| ovf | output | 1 | Counter wrap pulse |

## Verification
The duty values are tried in the cases that separate the comparison rules. A duty above the reload value gives a true pulse. A duty equal to the reload value and a duty of zero must both stay flat low, which exposes an off-by-one or a compare of the wrong sign. A duty of 0xFFF gives a one-cycle low notch.

Duty writes made mid-period, followed by later wraps, show whether the shadow-to-live transfer waits for the wrap. Break pulses are sent with the enable both clear and set, and clears are issued while the pin is low and while it is still high. Together these pin down the gating, the synchronizer latency, the latch hold and the set-over-clear priority.

A long random phase varies the reload value, the counter gating and register traffic. A per-cycle reference model checks every output and readback value against it.

// File: rtl/pwm_brk_pkg.sv
package pwm_brk_pkg;
  localparam int REG_W        = 8;
  localparam int BRK_EN_BIT   = 4;
  localparam int BRK_STAT_BIT = 5;
  localparam int BRK_CLR_BIT  = 6;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ovf   = en && (cnt_q == TOP);
    cnt_d = cnt_q;
    if (en) begin
      cnt_d = ovf ? reload : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_brk_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 12,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              brk_active,
  output logic [REG_W-1:0]  rdata,
  output logic [NCH*CW-1:0] shadow,
  output logic [NCH-1:0]    oe,
  output logic              brk_en,
  output logic [NCH-1:0]    brk_pat,
  output logic              brk_clr
);
  localparam int HI_W = CW - REG_W;
  localparam logic [AW-1:0] MODE_ADDR = AW'(2*NCH);
  localparam logic [AW-1:0] BRK_ADDR  = AW'(2*NCH+1);

  logic [CW-1:0]  shd_q [NCH];
  logic [NCH-1:0] oe_q, oe_d;
  logic           en_q, en_d;
  logic [NCH-1:0] pat_q, pat_d;
  logic           wr_mode, wr_brk;

  assign wr_mode = wr_en && (addr == MODE_ADDR);
  assign wr_brk  = wr_en && (addr == BRK_ADDR);

  for (genvar g = 0; g < NCH; g++) begin : g_duty
    logic          wr_lo, wr_hi;
    logic [CW-1:0] shd_d;
    assign wr_lo = wr_en && (addr == AW'(2*g));
    assign wr_hi = wr_en && (addr == AW'(2*g+1));
    always_comb begin
      shd_d = shd_q[g];
      if (wr_lo) shd_d[REG_W-1:0]  = wdata;
      if (wr_hi) shd_d[CW-1:REG_W] = wdata[HI_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shd_q[g] <= '0;
      else        shd_q[g] <= shd_d;
    end
    assign shadow[g*CW +: CW] = shd_q[g];
  end

  always_comb begin
    oe_d  = oe_q;
    en_d  = en_q;
    pat_d = pat_q;
    if (wr_mode) oe_d = wdata[NCH-1:0];
    if (wr_brk) begin
      en_d  = wdata[BRK_EN_BIT];
      pat_d = wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= '0;
      en_q  <= 1'b0;
      pat_q <= '0;
    end else begin
      oe_q  <= oe_d;
      en_q  <= en_d;
      pat_q <= pat_d;
    end
  end

  assign brk_clr = wr_brk && wdata[BRK_CLR_BIT];
  assign oe      = oe_q;
  assign brk_en  = en_q;
  assign brk_pat = pat_q;

  always_comb begin
    rdata = '0;
    if (addr < MODE_ADDR) begin
      if (addr[0]) rdata = REG_W'(shd_q[addr[AW-1:1]] >> REG_W);
      else         rdata = shd_q[addr[AW-1:1]][REG_W-1:0];
    end else if (addr == MODE_ADDR) begin
      rdata[NCH-1:0] = oe_q;
    end else if (addr == BRK_ADDR) begin
      rdata[NCH-1:0]      = pat_q;
      rdata[BRK_EN_BIT]   = en_q;
      rdata[BRK_STAT_BIT] = brk_active;
    end
  end
endmodule

// File: rtl/pwm_brk_ctrl.sv
module pwm_brk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_in,
  input  logic brk_en,
  input  logic brk_clr,
  output logic brk_active
);
  logic s1_q, s2_q;
  logic lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    if (s2_q && brk_en) lat_d = 1'b1;
    else if (brk_clr)   lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      s1_q  <= brk_in;
      s2_q  <= s1_q;
      lat_q <= lat_d;
    end
  end

  assign brk_active = lat_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf,
  input  logic [CW-1:0] shadow,
  input  logic [CW-1:0] cnt,
  input  logic          oe,
  output logic [CW-1:0] act,
  output logic          pwm,
  output logic          hit
);
  logic [CW-1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (ovf) act_d = shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act = act_q;
  assign pwm = oe && (cnt < act_q);
  assign hit = (cnt == act_q);
endmodule

// File: rtl/pwm_break_gen.sv
module pwm_break_gen
  import pwm_brk_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 12,
  parameter int AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             cnt_en,
  input  logic [CW-1:0]    reload_val,
  input  logic             brk_in,
  output logic [NCH-1:0]   pwm_out,
  output logic [NCH-1:0]   cmp_hit,
  output logic             ovf
);
  logic              rs1_q, rst_sync_n;
  logic [CW-1:0]     cnt;
  logic [NCH*CW-1:0] shadow;
  logic [NCH*CW-1:0] act_duty;
  logic [NCH-1:0]    oe, brk_pat, ch_pwm;
  logic              brk_en, brk_clr, brk_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  pwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(cnt_en), .reload(reload_val),
    .cnt(cnt), .ovf(ovf)
  );

  pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .brk_active(brk_active), .rdata(rdata), .shadow(shadow), .oe(oe),
    .brk_en(brk_en), .brk_pat(brk_pat), .brk_clr(brk_clr)
  );

  pwm_brk_ctrl u_brk (
    .clk(clk), .rst_n(rst_sync_n), .brk_in(brk_in), .brk_en(brk_en),
    .brk_clr(brk_clr), .brk_active(brk_active)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .ovf(ovf),
      .shadow(shadow[g*CW +: CW]), .cnt(cnt), .oe(oe[g]),
      .act(act_duty[g*CW +: CW]), .pwm(ch_pwm[g]), .hit(cmp_hit[g])
    );
  end

  assign pwm_out = brk_active ? brk_pat : ch_pwm;
endmodule

// File: rtl/pwm_break_chk.sv
module pwm_break_chk #(
  parameter int NCH = 4,
  parameter int CW  = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cnt_en,
  input logic [CW-1:0]     reload_val,
  input logic [CW-1:0]     cnt,
  input logic              ovf,
  input logic [NCH*CW-1:0] act_duty,
  input logic [NCH-1:0]    oe,
  input logic [NCH-1:0]    brk_pat,
  input logic [NCH-1:0]    pwm_out,
  input logic              brk_active,
  input logic              brk_en,
  input logic              brk_clr
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  a_r1_wrap_loads_reload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_en && cnt == TOP) |=> (cnt == $past(reload_val)));

  a_r1_step_up: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_en && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));

  a_r1_hold_when_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_en |=> $stable(cnt));

  a_r4_live_moves_on_wrap_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ovf |=> $stable(act_duty));

  a_r7_pattern_forced: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_active |-> (pwm_out == brk_pat));

  a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !brk_active |-> ((pwm_out & ~oe) == '0));

  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_active && !brk_clr) |=> brk_active);

  a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!brk_active && !brk_en) |=> !brk_active);
endmodule

bind pwm_break_gen pwm_break_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cnt_en(cnt_en), .reload_val(reload_val),
  .cnt(cnt), .ovf(ovf), .act_duty(act_duty), .oe(oe), .brk_pat(brk_pat),
  .pwm_out(pwm_out), .brk_active(brk_active), .brk_en(brk_en), .brk_clr(brk_clr)
);

// File: tb/tb_pwm_break_gen.sv
`timescale 1ns/1ps
module tb_pwm_break_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        cnt_en;
  logic [11:0] reload_val;
  logic        brk_in;
  logic [3:0]  pwm_out, cmp_hit;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit live   = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_break_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_en(cnt_en), .reload_val(reload_val), .brk_in(brk_in),
    .pwm_out(pwm_out), .cmp_hit(cmp_hit), .ovf(ovf)
  );

  // reference model built from the requirements
  logic        m_r1, m_r2;
  logic [11:0] m_cnt;
  logic [11:0] m_shd [4];
  logic [11:0] m_act [4];
  logic [3:0]  m_oe, m_pat;
  logic        m_en, m_s1, m_s2, m_lat;

  function automatic logic m_ovf();
    return cnt_en && (m_cnt == 12'hFFF);
  endfunction

  function automatic logic [3:0] exp_pwm();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = m_oe[i] && (m_cnt < m_act[i]);
    return m_lat ? m_pat : v;
  endfunction

  function automatic logic [3:0] exp_hit();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = (m_cnt == m_act[i]);
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a < 4'd8) return a[0] ? {4'h0, m_shd[a[2:1]][11:8]} : m_shd[a[2:1]][7:0];
    if (a == 4'd8) return {4'h0, m_oe};
    if (a == 4'd9) return {2'b00, m_lat, m_en, m_pat};
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 1'b0; m_r2 <= 1'b0;
    end else begin
      m_r1 <= 1'b1; m_r2 <= m_r1;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_r2) begin
      m_cnt <= '0; m_oe <= '0; m_pat <= '0; m_en <= 1'b0;
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_lat <= 1'b0;
      for (int i = 0; i < 4; i++) begin m_shd[i] <= '0; m_act[i] <= '0; end
    end else begin
      if (cnt_en) m_cnt <= m_ovf() ? reload_val : m_cnt + 12'd1;
      for (int i = 0; i < 4; i++) if (m_ovf()) m_act[i] <= m_shd[i];
      if (wr_en) begin
        if (addr < 4'd8) begin
          if (addr[0]) m_shd[addr[2:1]][11:8] <= wdata[3:0];
          else         m_shd[addr[2:1]][7:0]  <= wdata;
        end else if (addr == 4'd8) begin
          m_oe <= wdata[3:0];
        end else if (addr == 4'd9) begin
          m_pat <= wdata[3:0]; m_en <= wdata[4];
        end
      end
      m_s1 <= brk_in; m_s2 <= m_s1;
      if (m_s2 && m_en) m_lat <= 1'b1;
      else if (wr_en && addr == 4'd9 && wdata[6]) m_lat <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      check("R2 R3 R4 R7 pwm_out", {8'h0, pwm_out}, {8'h0, exp_pwm()});
      check("R5 cmp_hit", {8'h0, cmp_hit}, {8'h0, exp_hit()});
      check("R1 ovf", {11'h0, ovf}, {11'h0, m_ovf()});
      check("R9 rdata", {4'h0, rdata}, {4'h0, exp_rd(addr)});
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); #1;
    addr = a;
    #2;
    check(tag, {4'h0, rdata}, {4'h0, exp});
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0042);
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    cnt_en = 1'b0; reload_val = 12'hFF0; brk_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check("R10 pwm_out after reset", {8'h0, pwm_out}, 12'h0);
    check("R10 ovf after reset", {11'h0, ovf}, 12'h0);
    rd_chk("R10 duty reset", 4'd2, 8'h00);
    rd_chk("R10 brk ctrl reset", 4'd9, 8'h00);
    live = 1'b1;

    // R9 register map and reserved bits
    wr(4'd0, 8'hF8); wr(4'd1, 8'hFF);   // ch0 = 0xFF8
    wr(4'd2, 8'hF0); wr(4'd3, 8'hAF);   // ch1 = 0xFF0 (== reload)
    wr(4'd4, 8'hFF); wr(4'd5, 8'h0F);   // ch2 = 0xFFF
    wr(4'd8, 8'hFF);
    rd_chk("R9 high byte reserved bits zero", 4'd3, 8'h0F);
    rd_chk("R9 mode reg", 4'd8, 8'h0F);
    rd_chk("R9 unmapped", 4'd12, 8'h00);
    // R4 shadow not live before first wrap: all pwm low, counter stopped
    check("R4 no transfer without wrap", {8'h0, pwm_out}, 12'h0);

    // R1 R2 R5 main run
    cnt_en = 1'b1;
    idle(4200);
    // counter now cycles FF0..FFF: ch1 duty == reload must be flat low
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R2 duty equal reload is low", {11'h0, pwm_out[1]}, 12'h0);
    end
    // R4 mid-period rewrite of ch0
    wr(4'd0, 8'hF2);
    idle(40);

    // R6 break disabled: pin ignored
    wr(4'd9, 8'h05);
    @(negedge clk); #1 brk_in = 1'b1;
    idle(6);
    @(negedge clk); #1 brk_in = 1'b0;
    rd_chk("R6 disabled break not latched", 4'd9, 8'h05);

    // R7 enabled break forces pattern
    wr(4'd9, 8'h1A);
    @(negedge clk); #1 brk_in = 1'b1;
    @(negedge clk); #1 brk_in = 1'b0;
    idle(4);
    check("R7 pattern on outputs", {8'h0, pwm_out}, 12'h00A);
    // R8 hold after pin low
    idle(30);
    rd_chk("R8 latch held", 4'd9, 8'h3A);
    check("R8 pattern still forced", {8'h0, pwm_out}, 12'h00A);
    // R8 clear while pin high and enabled: stays set
    @(negedge clk); #1 brk_in = 1'b1;
    idle(3);
    wr(4'd9, 8'h5A);
    rd_chk("R8 set wins over clear", 4'd9, 8'h3A);
    @(negedge clk); #1 brk_in = 1'b0;
    idle(4);
    wr(4'd9, 8'h5A);
    rd_chk("R8 clear releases latch", 4'd9, 8'h1A);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk); #1;
      wr_en  = ($urandom_range(9, 0) < 3);
      addr   = 4'($urandom_range(11, 0));
      wdata  = 8'($urandom);
      if (addr == 4'd9 && $urandom_range(3, 0) != 0) wdata[6] = 1'b1;
      cnt_en = ($urandom_range(9, 0) != 0);
      if ($urandom_range(99, 0) == 0) brk_in = ~brk_in;
      if ($urandom_range(499, 0) == 0) reload_val = {4'hF, 8'($urandom)};
    end
    @(negedge clk); #1 wr_en = 1'b0;
    idle(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule